// File: doc/BRIEF.md
# Write-Once Memory Timing Tick Generator

This block produces the timing base for erase and program operations on on-chip nonvolatile memory. It runs from the bus clock. A single 8-bit configuration register picks an optional divide-by-eight prescale stage and a 6-bit divisor value N. The block then issues a one-bus-cycle tick once per divided period, which is (N+1) bus cycles, or 8·(N+1) bus cycles when the prescale stage is selected. The erase and program sequencer counts whole ticks to time its pulses. The divided clock is never a gated clock; it exists only as this tick enable.

The register accepts one write after reset and no more. That first write stores the prescale bit and the divisor, and it sets a read-only loaded flag whatever data it carries. The loaded flag drives the operation-enable output, so erase and program stay blocked until software has set up the timing. The same write restarts both counters from zero, so the first tick comes a full divided period after the write.

Two small state machines control the block. The register machine has the states `CFG_OPEN` and `CFG_SEALED`. Its only transition is OPEN→SEALED, taken on the first write strobe. The divider machine has the states `DIV_IDLE` and `DIV_RUN`. Its only transition is IDLE→RUN, taken on that same write. Reset returns both machines to their first state.

Top module: `nvm_tick_gen`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads 0x00, `cfg_loaded` and `nvm_op_en` are 0, and `tick` is 0.
- R2: The first `cfg_we` pulse after reset sets `cfg_loaded` and `nvm_op_en` from the next cycle onward, whatever the value of `cfg_wdata`, including bit 7. The flag never falls until reset.
- R3: `cfg_rdata` returns the loaded flag in bit 7, the stored prescale select in bit 6 and the stored divisor in bits 5:0. Bits 6:0 come from bits 6:0 of the first write.
- R4: Every write after the first is ignored. `cfg_rdata`, `cfg_loaded` and the tick period all stay unchanged.
- R5: No tick is produced while `cfg_loaded` is 0.
- R6: With the prescale bit at 0 and divisor N, `tick` is high for exactly one cycle in every N+1 bus cycles. With N=0, `tick` is high in every cycle.
- R7: With the prescale bit at 1 and divisor N, `tick` is high for exactly one cycle in every 8·(N+1) bus cycles.
- R8: Count the cycle after the write edge as cycle 1. The first tick then appears in cycle P, where P is the full divided period, and later ticks follow in cycles 2P, 3P and so on.
- R9: A write that is ignored does not shift the phase of the running tick sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe, one per write |
| cfg_wdata | input | 8 | Write data: bit 6 prescale select, bits 5:0 divisor; bit 7 ignored |
| cfg_rdata | output | 8 | Readback: loaded flag, prescale select, divisor |
| tick | output | 1 | One-cycle enable per divided period |
| cfg_loaded | output | 1 | Set by the first write since reset |
| nvm_op_en | output | 1 | Erase and program allowed |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor and a prescale ratio of 8. This gives periods from 1 to 512 bus cycles, so every trial can observe two full periods in well under the cycle limit. Directed trials cover the extremes: the shortest period (N=0, no prescale), which ticks every cycle, and the longest (N=63 with prescale). Seeded random register values fill in between them. Every trial also makes a second write partway through the first period, which must leave the readback and the tick phase untouched.

// File: rtl/nvmclk_pkg.sv
package nvmclk_pkg;

    // Register lock state: open until the first write lands.
    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_SEALED = 1'b1
    } cfg_state_t;

    // Divider activity: idle until configured, then free-running.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;

endpackage

// File: rtl/nvmclk_cfg_reg.sv
module nvmclk_cfg_reg
    import nvmclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DIV_W:0]   wdata,
    output logic             loaded,
    output logic             pre_sel,
    output logic [DIV_W-1:0] divisor,
    output logic             restart
);

    cfg_state_t state_q, state_d;
    logic             pre_q;
    logic [DIV_W-1:0] div_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CFG_OPEN;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (we) state_d = CFG_SEALED;
            CFG_SEALED: state_d = CFG_SEALED;
            default:    state_d = CFG_OPEN;
        endcase
    end

    // Stored fields: captured only on the OPEN->SEALED transition
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= 1'b0;
            div_q <= '0;
        end else if (state_q == CFG_OPEN && we) begin
            pre_q <= wdata[DIV_W];
            div_q <= wdata[DIV_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        loaded  = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            CFG_OPEN:   restart = we;
            CFG_SEALED: loaded  = 1'b1;
            default:    loaded  = 1'b0;
        endcase
        pre_sel = pre_q;
        divisor = div_q;
    end

endmodule

// File: rtl/nvmclk_prescale.sv
module nvmclk_prescale #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic sel,
    output logic stage_en
);

    generate
        if (RATIO < 2) begin : g_bypass
            assign stage_en = run;
        end else begin : g_count
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || restart)       cnt_q <= '0;
                else if (run && sel)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            assign stage_en = run && (!sel || cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/nvmclk_divider.sv
module nvmclk_divider
    import nvmclk_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             stage_en,
    input  logic [DIV_W-1:0] divisor,
    output logic             running,
    output logic             tick
);

    div_state_t state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= DIV_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (restart) state_d = DIV_RUN;
            DIV_RUN:  state_d = DIV_RUN;
            default:  state_d = DIV_IDLE;
        endcase
    end

    assign wrap = (cnt_q == divisor);

    // Counter: divide by divisor+1
    always_ff @(posedge clk) begin
        if (rst || restart)                       cnt_q <= '0;
        else if (state_q == DIV_RUN && stage_en)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Outputs
    always_comb begin
        running = 1'b0;
        tick    = 1'b0;
        unique case (state_q)
            DIV_IDLE: ;
            DIV_RUN: begin
                running = 1'b1;
                tick    = stage_en && wrap;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W     = 6,
    parameter int PRE_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [DIV_W+1:0] cfg_wdata,
    output logic [DIV_W+1:0] cfg_rdata,
    output logic             tick,
    output logic             cfg_loaded,
    output logic             nvm_op_en
);

    logic             loaded;
    logic             pre_sel;
    logic [DIV_W-1:0] divisor;
    logic             restart;
    logic             stage_en;
    logic             running;

    nvmclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata[DIV_W:0]),
        .loaded  (loaded),
        .pre_sel (pre_sel),
        .divisor (divisor),
        .restart (restart)
    );

    nvmclk_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (running),
        .sel      (pre_sel),
        .stage_en (stage_en)
    );

    nvmclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .stage_en (stage_en),
        .divisor  (divisor),
        .running  (running),
        .tick     (tick)
    );

    assign cfg_rdata  = {loaded, pre_sel, divisor};
    assign cfg_loaded = loaded;
    assign nvm_op_en  = loaded;

endmodule

// File: rtl/nvm_tick_gen_chk.sv
module nvm_tick_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic       tick,
    input logic       cfg_loaded,
    input logic       nvm_op_en
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(cfg_we)) |-> (cfg_rdata == 8'h00 && !cfg_loaded && !tick));

    // R2
    first_write_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_loaded) |=> (cfg_loaded && nvm_op_en));

    // R2
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_loaded |=> cfg_loaded);

    // R4
    sealed_stable_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_loaded |=> $stable(cfg_rdata));

    // R5
    no_tick_unloaded_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_loaded |-> !tick);

    // R6
    single_cycle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg_rdata[6:0] != 7'd0) |=> !tick);

endmodule

bind nvm_tick_gen nvm_tick_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .tick       (tick),
    .cfg_loaded (cfg_loaded),
    .nvm_op_en  (nvm_op_en)
);

// File: tb/tb_nvm_tick_gen.sv
module tb_nvm_tick_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tick;
    logic       cfg_loaded;
    logic       nvm_op_en;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nvm_tick_gen dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .tick       (tick),
        .cfg_loaded (cfg_loaded),
        .nvm_op_en  (nvm_op_en)
    );

    function automatic int period_of(input logic [7:0] d);
        return (int'(d[5:0]) + 1) * (d[6] ? 8 : 1);
    endfunction

    function automatic logic [7:0] readback_of(input logic [7:0] d);
        return {1'b1, d[6:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic trial(input logic [7:0] data, input logic [7:0] late);
        int p;
        int stop;
        int late_at;
        p = period_of(data);
        stop = 2 * p + 2;
        late_at = p / 2 + 1;
        @(negedge clk);
        rst = 1'b1;
        cfg_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 rdata", cfg_rdata, 8'h00);
            check("R1 loaded", {cfg_loaded, nvm_op_en}, 0);
            check("R5 tick", tick, 0);
        end
        cfg_we = 1'b1;
        cfg_wdata = data;
        for (int k = 1; k <= stop; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (k == 1) begin
                check("R2 loaded", {cfg_loaded, nvm_op_en}, 3);
                check("R3 readback", cfg_rdata, readback_of(data));
            end
            if (k == late_at + 1)
                check("R4 ignored write", cfg_rdata, readback_of(data));
            if (k == stop)
                check("R4 flag kept", cfg_loaded, 1);
            if (k <= p)
                check(data[6] ? "R8 R7 first tick" : "R8 R6 first tick", tick, (k == p) ? 1 : 0);
            else
                check(data[6] ? "R9 R7 period" : "R9 R6 period", tick, (k % p == 0) ? 1 : 0);
            if (k == late_at) begin
                cfg_we = 1'b1;
                cfg_wdata = late;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (2) @(negedge clk);
        trial(8'h00, 8'h7F);
        trial(8'h7F, 8'h00);
        trial(8'hC0, 8'h3F);
        trial(8'h83, 8'h41);
        trial(8'h05, 8'hFF);
        for (int t = 0; t < 12; t++) begin
            logic [7:0] d;
            logic [7:0] l;
            d = 8'($urandom);
            l = 8'($urandom);
            trial(d, l);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule